// File: doc/BRIEF.md
# Banked Instruction Cache Refill Coordinator

This block is the central bookkeeping point for an instruction cache whose line storage is split across several independent banks. It alone keeps the tag and valid state of every line. Each fetch lookup is compared against that state. When a fetch misses and no refill is already running, the block sends the missing block address to all banks at once on a one-cycle refill broadcast.

Each bank then fills its own share of the line, two 64-byte chunks. Banks do this at their own pace and report back with a one-cycle done pulse. The coordinator clears one bit of a pending mask for every report. In the cycle the mask empties, it marks the line valid, writes its tag and raises a one-cycle dispatch-ready pulse, so fetch of the block can proceed.

Only one refill is in flight at a time. A done pulse from a bank that owes nothing is ignored and latches an error flag.

Top module: `icache_refill_ctrl`

## Requirements
- R1: After reset, no line is valid: every fetch address misses (`fetchHit` low). `busy`, `refillValid`, `dispatchReady` and `errFlag` are all low.
- R2: A fetch that misses while `busy` is low is accepted. In the next cycle `refillValid` is high for exactly one cycle, `refillAddr` equals the fetch block address and `busy` is high.
- R3: While `busy` is high, a missing fetch starts nothing. `refillValid` stays low and `refillAddr` keeps the address of the current refill.
- R4: Banks may report in any order and at any delay. `dispatchReady` stays low until every one of the `NUM_BANKS` banks has pulsed its own `bankDone` bit once for the current refill.
- R5: `dispatchReady` is a one-cycle pulse in the cycle after the last outstanding done is sampled. In that same cycle `busy` is low and `refillAddr` still names the refilled block.
- R6: In the cycle `dispatchReady` is high, the line is already valid: a fetch of the refilled address shows `fetchHit` high in that cycle.
- R7: A `bankDone` pulse from a bank that is not pending, whether the block is idle or the bank has already reported, is ignored. It sets `errFlag`, which stays high until reset. `errFlag` never rises otherwise.
- R8: The cache is direct mapped. The low `INDEX_W` bits of the block address select the set, and the remaining upper bits form the tag. A valid line hits only when its tag matches, and a refill into an occupied set replaces the older line.
- R9: Done pulses that arrive in the same cycle `refillValid` is high are counted. A refill whose banks all report in that cycle gives `dispatchReady` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fetchValid | input | 1 | A fetch lookup is presented this cycle |
| fetchAddr | input | BLK_W (12) | Block address of the fetch |
| fetchHit | output | 1 | Combinational: the fetch block is valid with a matching tag |
| refillValid | output | 1 | One-cycle broadcast of a new refill to all banks |
| refillAddr | output | BLK_W (12) | Block address of the current or most recent refill |
| bankDone | input | NUM_BANKS (5) | Per-bank refill completion pulses |
| busy | output | 1 | A refill is outstanding |
| dispatchReady | output | 1 | One-cycle pulse: all banks finished, block may dispatch |
| errFlag | output | 1 | Sticky: a done pulse arrived from a bank that was not pending |

## Verification
A pending bit that is lost or cleared by the wrong bank shows up as a mistimed `dispatchReady`. The pulse then comes one or more cycles before the slowest bank in the stimulus reports, or it never comes at all. A tag or valid bit written in the wrong cycle or set shows as a `fetchHit` mismatch in the very `dispatchReady` cycle, or later when the line is fetched again. A busy state that fails to block new misses shows as a second `refillValid` pulse, or a changed `refillAddr`, one cycle after the rejected miss. A wrong error decision shows as `errFlag` rising during clean refills, or staying low one cycle after a stray pulse.

// File: rtl/icache_refill_pkg.sv
package icache_refill_pkg;
  typedef struct packed {
    logic startRefill;
    logic finishRefill;
  } refill_strobe_t;
endpackage

// File: rtl/icache_refill_dp.sv
module icache_refill_dp
  import icache_refill_pkg::*;
#(
  parameter int BLK_W   = 12,
  parameter int INDEX_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  refill_strobe_t   strb,
  input  logic [BLK_W-1:0] fetchAddr,
  output logic             fetchHit,
  output logic [BLK_W-1:0] refillAddr
);
  localparam int NUM_SETS = 1 << INDEX_W;
  localparam int TAG_W    = BLK_W - INDEX_W;

  logic [TAG_W-1:0]   tagMem [NUM_SETS];
  logic [NUM_SETS-1:0] validBits;
  logic [INDEX_W-1:0] fetchIdx, refIdx;
  logic [TAG_W-1:0]   fetchTag, refTag;

  assign fetchIdx = fetchAddr[INDEX_W-1:0];
  assign fetchTag = fetchAddr[BLK_W-1:INDEX_W];
  assign refIdx   = refillAddr[INDEX_W-1:0];
  assign refTag   = refillAddr[BLK_W-1:INDEX_W];

  always_ff @(posedge clk) begin
    if (!rstN) refillAddr <= '0;
    else if (strb.startRefill) refillAddr <= fetchAddr;
  end

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    always_ff @(posedge clk) begin
      if (!rstN) validBits[s] <= 1'b0;
      else if (strb.finishRefill && refIdx == INDEX_W'(s)) validBits[s] <= 1'b1;
    end
    always_ff @(posedge clk) begin
      if (strb.finishRefill && refIdx == INDEX_W'(s)) tagMem[s] <= refTag;
    end
  end

  assign fetchHit = validBits[fetchIdx] && (tagMem[fetchIdx] == fetchTag);

  // R6: the finished line is valid in the following cycle
  a_r6_line_valid_after_finish: assert property (@(posedge clk) disable iff (!rstN)
    strb.finishRefill |=> validBits[$past(refIdx)]);

  // R2: the refill address holds still unless a refill is starting
  a_r2_addr_holds: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.startRefill) && $past(rstN) |-> $stable(refillAddr));
endmodule

// File: rtl/icache_refill_fsm.sv
module icache_refill_fsm
  import icache_refill_pkg::*;
#(
  parameter int NUM_BANKS = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 fetchValid,
  input  logic                 fetchHit,
  input  logic [NUM_BANKS-1:0] bankDone,
  output refill_strobe_t       strb,
  output logic                 refillValid,
  output logic                 busy,
  output logic                 dispatchReady,
  output logic                 errFlag
);
  logic [NUM_BANKS-1:0] pending, pendingNext;
  logic stray;

  assign pendingNext       = pending & ~bankDone;
  assign stray             = |(bankDone & ~pending);
  assign strb.startRefill  = !busy && fetchValid && !fetchHit;
  assign strb.finishRefill = busy && (pendingNext == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending       <= '0;
      busy          <= 1'b0;
      refillValid   <= 1'b0;
      dispatchReady <= 1'b0;
      errFlag       <= 1'b0;
    end else begin
      refillValid   <= strb.startRefill;
      dispatchReady <= strb.finishRefill;
      if (stray) errFlag <= 1'b1;
      if (strb.startRefill) begin
        pending <= '1;
        busy    <= 1'b1;
      end else if (busy) begin
        pending <= pendingNext;
        if (strb.finishRefill) busy <= 1'b0;
      end
    end
  end

  // R2: a new refill broadcast goes out when the block becomes busy
  a_r2_broadcast_on_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> refillValid);

  // R3: no broadcast while a refill was already running
  a_r3_single_outstanding: assert property (@(posedge clk) disable iff (!rstN)
    busy && refillValid |=> !refillValid);

  // R4: pending bits only clear while a refill runs
  a_r4_pending_only_clears: assert property (@(posedge clk) disable iff (!rstN)
    busy && $past(busy) |-> (pending & ~$past(pending)) == '0);

  // R5: dispatch is a single pulse ending a busy period
  a_r5_dispatch_ends_busy: assert property (@(posedge clk) disable iff (!rstN)
    dispatchReady |-> !busy && $past(busy));

  a_r5_dispatch_pulse: assert property (@(posedge clk) disable iff (!rstN)
    dispatchReady |=> !dispatchReady);

  // R7: the error flag is sticky
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);
endmodule

// File: rtl/icache_refill_ctrl.sv
module icache_refill_ctrl
  import icache_refill_pkg::*;
#(
  parameter int NUM_BANKS = 5,
  parameter int BLK_W     = 12,
  parameter int INDEX_W   = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 fetchValid,
  input  logic [BLK_W-1:0]     fetchAddr,
  output logic                 fetchHit,
  output logic                 refillValid,
  output logic [BLK_W-1:0]     refillAddr,
  input  logic [NUM_BANKS-1:0] bankDone,
  output logic                 busy,
  output logic                 dispatchReady,
  output logic                 errFlag
);
  refill_strobe_t strb;

  icache_refill_fsm #(.NUM_BANKS(NUM_BANKS)) u_fsm (
    .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .fetchHit(fetchHit),
    .bankDone(bankDone), .strb(strb), .refillValid(refillValid), .busy(busy),
    .dispatchReady(dispatchReady), .errFlag(errFlag)
  );

  icache_refill_dp #(.BLK_W(BLK_W), .INDEX_W(INDEX_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .fetchAddr(fetchAddr),
    .fetchHit(fetchHit), .refillAddr(refillAddr)
  );
endmodule

// File: tb/icache_refill_ctrl_test.sv
module icache_refill_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 5;
  localparam int AW = 12;
  localparam int NVEC = 6;
  // {addr[11:0], delay bank4..bank0 (4 bits each)}
  localparam logic [31:0] VEC [NVEC] = '{
    {12'h123, 20'h00000}, {12'h2A5, 20'h43210}, {12'h0F7, 20'h15037},
    {12'h4CB, 20'h99999}, {12'h350, 20'h0000F}, {12'h7EE, 20'h22222}
  };

  logic clk = 0, rstN = 0, fetchValid = 0;
  logic [AW-1:0] fetchAddr = '0;
  logic [NB-1:0] bankDone = '0;
  logic fetchHit, refillValid, busy, dispatchReady, errFlag;
  logic [AW-1:0] refillAddr;
  int nRun = 0, nFail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  icache_refill_ctrl uut (
    .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .fetchAddr(fetchAddr),
    .fetchHit(fetchHit), .refillValid(refillValid), .refillAddr(refillAddr),
    .bankDone(bankDone), .busy(busy), .dispatchReady(dispatchReady), .errFlag(errFlag)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Present a missing fetch at a negedge; at the next negedge check the broadcast (R2).
  task automatic startMiss(input logic [AW-1:0] a);
    fetchValid = 1; fetchAddr = a;
    #1 check(fetchHit == 0, "R8 miss before refill", fetchHit, 0);
    @(negedge clk);
    fetchValid = 0;
    check(refillValid == 1, "R2 refillValid", refillValid, 1);
    check(refillAddr == a, "R2 refillAddr", refillAddr, a);
    check(busy == 1, "R2 busy", busy, 1);
  endtask

  // Drive bank pulses per delay table; dispatch expected at cycle maxD+1 (R4 R5 R6 R9).
  task automatic runBanks(input logic [AW-1:0] a, input logic [19:0] dl);
    int maxD = 0;
    for (int b = 0; b < NB; b++) if (int'(dl[4*b +: 4]) > maxD) maxD = int'(dl[4*b +: 4]);
    for (int k = 0; k <= maxD + 1; k++) begin
      if (k == maxD + 1) begin
        fetchValid = 1; fetchAddr = a;
        #1;
        check(dispatchReady == 1, "R5 dispatchReady on time", dispatchReady, 1);
        check(busy == 0, "R5 busy low at dispatch", busy, 0);
        check(refillAddr == a, "R5 refillAddr at dispatch", refillAddr, a);
        check(fetchHit == 1, "R6 hit in dispatch cycle", fetchHit, 1);
        fetchValid = 0;
      end else begin
        check(dispatchReady == 0, "R4 no early dispatch", dispatchReady, 0);
        for (int b = 0; b < NB; b++) bankDone[b] = (int'(dl[4*b +: 4]) == k);
      end
      @(negedge clk);
      bankDone = '0;
    end
    check(dispatchReady == 0, "R5 dispatch one cycle", dispatchReady, 0);
  endtask

  task automatic probe(input logic [AW-1:0] a, input bit exp, input string req);
    fetchValid = 1; fetchAddr = a;
    #1 check(fetchHit == exp, req, fetchHit, exp);
    fetchValid = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nRun++; nFail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    check(busy == 0, "R1 busy", busy, 0);
    check(refillValid == 0, "R1 refillValid", refillValid, 0);
    check(dispatchReady == 0, "R1 dispatchReady", dispatchReady, 0);
    check(errFlag == 0, "R1 errFlag", errFlag, 0);
    probe(12'h000, 0, "R1 no valid line");
    probe(12'h123, 0, "R1 no valid line");

    // Vector table
    for (int v = 0; v < NVEC; v++) begin
      startMiss(VEC[v][31:20]);
      runBanks(VEC[v][31:20], VEC[v][19:0]);
    end
    for (int v = 0; v < NVEC; v++) probe(VEC[v][31:20], 1, "R8 hit after fill");
    check(errFlag == 0, "R7 no error on clean refills", errFlag, 0);

    // R3: a miss during busy is not accepted
    startMiss(12'h561);
    fetchValid = 1; fetchAddr = 12'h562;
    @(negedge clk);
    fetchValid = 0;
    check(refillValid == 0, "R3 no second broadcast", refillValid, 0);
    check(refillAddr == 12'h561, "R3 refillAddr held", refillAddr, 12'h561);
    runBanks(12'h561, 20'h11111);
    probe(12'h562, 0, "R3 blocked miss not filled");

    // R8 conflict: same set, different tag replaces line 0x123
    startMiss(12'h9A3);
    runBanks(12'h9A3, 20'h01230);
    probe(12'h123, 0, "R8 old line replaced");
    probe(12'h9A3, 1, "R8 new line hits");

    // R7: repeated done from a bank during busy is ignored
    startMiss(12'h33C);
    bankDone = 5'b00001;
    @(negedge clk);
    bankDone = 5'b00001;
    @(negedge clk);
    bankDone = '0;
    check(errFlag == 1, "R7 duplicate done flags error", errFlag, 1);
    check(dispatchReady == 0 && busy == 1, "R7 duplicate ignored", {dispatchReady, busy}, 1);
    bankDone = 5'b11110;
    @(negedge clk);
    bankDone = '0;
    check(dispatchReady == 1, "R7 refill completes after others", dispatchReady, 1);

    // R7: stray while idle, and stickiness
    rstN = 0; @(negedge clk); rstN = 1;
    check(errFlag == 0, "R1 errFlag cleared by reset", errFlag, 0);
    bankDone = 5'b00100;
    @(negedge clk);
    bankDone = '0;
    check(errFlag == 1, "R7 idle stray flags error", errFlag, 1);
    check(busy == 0 && refillValid == 0, "R7 idle stray ignored", {busy, refillValid}, 0);
    repeat (3) @(negedge clk);
    check(errFlag == 1, "R7 errFlag sticky", errFlag, 1);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule